// File: doc/BRIEF.md
# Sixteen-Channel Converter Register Controller

This block sits between a simple register bus and an auxiliary analog-to-digital converter that serves sixteen inputs. Software turns the converter on through a power-enable bit. It then requests a sample on an input by raising that input's bit in a shared trigger register. The block queues every requested input and hands the inputs to the converter one at a time through a start/channel/done handshake. It keeps the latest result of each input, together with a ready flag, in a per-input data word.

A 0-to-1 edge on a trigger bit is what requests a sample. The usual software sequence is to clear the bit, confirm that the input's ready flag reads 0, set the bit, and then poll the ready flag, or the global busy bit, until the sample has landed. When several inputs are requested together, they are converted in ascending index order. The busy bit stays high until the whole queue has drained.

Top module: `auxconv_ctrl`

## Requirements
- R1: After reset, every readable register reads 0: the trigger word, the status word, the power word and all sixteen data words. `conv_start` is low.
- R2: While power is enabled, a 0-to-1 edge written to trigger bit n (offset 0x04) clears the ready flag of input n at once. It also later issues one `conv_start` pulse with `conv_chan` = n, and `conv_chan` holds that value until the conversion ends.
- R3: When `conv_done` arrives for the input in flight, `conv_data` is stored in bits [11:0] of that input's data word at offset 0x14 + 4*n, and bit 12 (ready) is set. The data words of all other inputs are unchanged.
- R4: Inputs requested in the same write are converted one at a time in ascending index order. A new `conv_start` is issued only when no conversion is in flight, and each pulse lasts one cycle.
- R5: Bit 0 of the status word (offset 0x10) reads 1 from the cycle after an accepted request until the queue is empty and no conversion is in flight, and 0 otherwise.
- R6: Bit 14 of the word at offset 0x94 is a read/write power enable. A trigger edge written while it is 0 is dropped: no conversion starts, and that input's ready flag and result stay as they were.
- R7: The trigger word reads back the value last written. Writing 1 to a bit that already holds 1 requests nothing.
- R8: Writes to the status word, to the data words and to unmapped offsets (for example 0x00, 0x08, 0x15, 0x58) have no effect, and reads from unmapped offsets return 0.
- R9: A `conv_done` pulse that arrives while no conversion is in flight changes no data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from register state |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_chan | output | 4 | Input selected for the conversion in flight |
| conv_data | input | 12 | Result from the converter |
| conv_done | input | 1 | One-cycle pulse that marks `conv_data` valid |

## Verification
The queue is exercised with a single request on a middle input, with a burst of four requests spread across the index range (first and last input included), and with a rewrite that adds one bit to an already-set word. The single request shows that the right input is started and that its result lands in the right data word. The burst tells ascending-order service apart from any other ordering and shows that busy covers the whole queue. The rewrite tells edge detection apart from level detection. Requests made with power off, a stray done pulse and writes to read-only or unmapped offsets are each followed by a full readback, so that a change to any stored word is detected.

// File: rtl/auxconv_pkg.sv
package auxconv_pkg;
    localparam logic [7:0] OFS_TRIG  = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_DATA0 = 8'h14;
    localparam logic [7:0] OFS_MISC  = 8'h94;

    localparam int BUSY_BIT  = 0;
    localparam int READY_BIT = 12;
    localparam int PWR_BIT   = 14;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_e;
endpackage

// File: rtl/auxconv_decode.sv
module auxconv_decode
    import auxconv_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_trig,
    output logic              hit_stat,
    output logic              hit_misc,
    output logic              hit_data,
    output logic [IDX_W-1:0]  data_idx
);
    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = addr - ADDR_W'(OFS_DATA0);
        hit_trig = (addr == ADDR_W'(OFS_TRIG));
        hit_stat = (addr == ADDR_W'(OFS_STAT));
        hit_misc = (addr == ADDR_W'(OFS_MISC));
        hit_data = (addr >= ADDR_W'(OFS_DATA0)) && (off[1:0] == 2'b00)
                   && (int'(off[ADDR_W-1:2]) < N_CH);
        data_idx = off[IDX_W+1:2];
    end
endmodule

// File: rtl/auxconv_pick.sv
module auxconv_pick #(
    parameter int N_CH   = 16,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N_CH-1:0]  onehot
);
    always_comb begin
        any    = |req;
        idx    = '0;
        onehot = req & (~req + N_CH'(1));
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/auxconv_ctrl.sv
module auxconv_ctrl
    import auxconv_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int RES_W  = 12,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_start,
    output logic [IDX_W-1:0]  conv_chan,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              conv_done
);
    typedef struct packed {
        seq_e                  seq;
        logic [N_CH-1:0]       trig;
        logic [N_CH-1:0]       pend;
        logic [N_CH-1:0]       rdy;
        logic [N_CH*RES_W-1:0] res;
        logic                  pwr;
        logic                  start;
        logic [IDX_W-1:0]      chan;
    } state_t;

    state_t st_d, st_q;

    logic             hit_trig, hit_stat, hit_misc, hit_data;
    logic [IDX_W-1:0] data_idx;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [N_CH-1:0]  pick_oh;
    logic [N_CH-1:0]  rise_d;
    logic [N_CH-1:0]  accept_d;
    logic             in_flight;
    logic             busy;

    auxconv_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr     (bus_addr),
        .hit_trig (hit_trig),
        .hit_stat (hit_stat),
        .hit_misc (hit_misc),
        .hit_data (hit_data),
        .data_idx (data_idx)
    );

    auxconv_pick #(.N_CH(N_CH)) u_pick (
        .req    (st_q.pend),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    assign in_flight  = (st_q.seq == SEQ_WAIT);
    assign busy       = in_flight || (|st_q.pend);
    assign conv_start = st_q.start;
    assign conv_chan  = st_q.chan;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        rise_d   = (bus_we && hit_trig) ? (bus_wdata[N_CH-1:0] & ~st_q.trig) : '0;
        accept_d = st_q.pwr ? rise_d : '0;

        if (bus_we && hit_trig) st_d.trig = bus_wdata[N_CH-1:0];
        if (bus_we && hit_misc) st_d.pwr  = bus_wdata[PWR_BIT];

        case (st_q.seq)
            SEQ_IDLE: begin
                if (pick_any) begin
                    st_d.seq   = SEQ_WAIT;
                    st_d.start = 1'b1;
                    st_d.chan  = pick_idx;
                    st_d.pend  = st_q.pend & ~pick_oh;
                end
            end
            SEQ_WAIT: begin
                if (conv_done) begin
                    st_d.seq = SEQ_IDLE;
                    for (int i = 0; i < N_CH; i++) begin
                        if (IDX_W'(i) == st_q.chan) begin
                            st_d.rdy[i]                  = 1'b1;
                            st_d.res[i*RES_W +: RES_W] = conv_data;
                        end
                    end
                end
            end
            default: st_d.seq = SEQ_IDLE;
        endcase

        st_d.pend = st_d.pend | accept_d;
        st_d.rdy  = st_d.rdy & ~accept_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_trig) bus_rdata[N_CH-1:0] = st_q.trig;
        if (hit_stat) bus_rdata[BUSY_BIT] = busy;
        if (hit_misc) bus_rdata[PWR_BIT]  = st_q.pwr;
        if (hit_data) begin
            for (int i = 0; i < N_CH; i++) begin
                if (IDX_W'(i) == data_idx) begin
                    bus_rdata[RES_W-1:0] = st_q.res[i*RES_W +: RES_W];
                    bus_rdata[READY_BIT] = st_q.rdy[i];
                end
            end
        end
    end
endmodule

// File: rtl/auxconv_ctrl_chk.sv
module auxconv_ctrl_chk #(
    parameter int N_CH   = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic [IDX_W-1:0]  conv_chan,
    input logic              conv_done,
    input logic              in_flight,
    input logic              busy,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(in_flight));

    assert_chan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && !conv_start) |-> $stable(conv_chan));

    assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && conv_done) |=> !in_flight);

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8'h0C)) |-> (bus_rdata == '0));
endmodule

bind auxconv_ctrl auxconv_ctrl_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .in_flight  (in_flight),
    .busy       (busy),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/auxconv_ctrl_tb.sv
`timescale 1ns/1ps
module auxconv_ctrl_tb;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic [11:0] conv_data = '0;
    logic        conv_done = 1'b0;

    int checks = 0;
    int fails = 0;
    int log_n = 0;
    int log_chan [64];
    logic [11:0] salt = 12'h000;
    logic        stray = 1'b0;
    logic [12:0] exp_word [16];

    always #10 clk = ~clk;

    auxconv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_data(conv_data), .conv_done(conv_done)
    );

    function automatic logic [11:0] sample_val(int ch, logic [11:0] s);
        return 12'(ch * 12'h111) + s;
    endfunction

    // converter stub: LAT negedges after a start, pulse done with a value
    initial begin
        int cnt = 0;
        int ch = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (stray) begin
                conv_done = 1'b1;
                conv_data = 12'hFFF;
                stray = 1'b0;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    conv_done = 1'b1;
                    conv_data = sample_val(ch, salt);
                end
            end else if (conv_start) begin
                ch  = int'(conv_chan);
                cnt = LAT;
                if (log_n < 64) log_chan[log_n] = ch;
                log_n++;
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            bus_read(8'h10, v);
            if (v[0] == 1'b0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all_data(string tag);
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            bus_read(8'(8'h14 + 4 * i), v);
            check(tag, v, {19'd0, exp_word[i]});
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 conv_start", {31'd0, conv_start}, 32'd0);
        bus_read(8'h04, v); check("R1 trig", v, 32'd0);
        bus_read(8'h10, v); check("R1 status", v, 32'd0);
        bus_read(8'h94, v); check("R1 power", v, 32'd0);
        check_all_data("R1 data");
    endtask

    task automatic t_power_off();
        logic [31:0] v;
        log_n = 0;
        bus_write(8'h04, 32'h0000_0001);
        repeat (20) @(negedge clk);
        check("R6 no start", log_n, 0);
        bus_read(8'h10, v); check("R6 status idle", v, 32'd0);
        bus_read(8'h04, v); check("R7 trig readback", v, 32'h1);
        bus_read(8'h14, v); check("R6 ready kept", v, 32'd0);
        bus_write(8'h04, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        bus_write(8'h94, 32'h0000_4000);
        bus_read(8'h94, v); check("R6 power readback", v, 32'h4000);
        salt = 12'h003; log_n = 0;
        bus_write(8'h04, 32'h0000_0020);
        bus_read(8'h10, v); check("R5 busy high", v, 32'h1);
        wait_idle();
        bus_read(8'h10, v); check("R5 busy low", v, 32'h0);
        check("R2 one start", log_n, 1);
        check("R2 chan", log_chan[0], 5);
        exp_word[5] = {1'b1, sample_val(5, salt)};
        check_all_data("R3 data");
    endtask

    task automatic t_multi();
        logic [31:0] v;
        bus_write(8'h04, 32'h0);
        salt = 12'h020; log_n = 0;
        bus_write(8'h04, 32'h0000_8421);
        bus_read(8'h28, v); check("R2 ready cleared", v[12], 1'b0);
        wait_idle();
        check("R4 count", log_n, 4);
        check("R4 order 0", log_chan[0], 0);
        check("R4 order 1", log_chan[1], 5);
        check("R4 order 2", log_chan[2], 10);
        check("R4 order 3", log_chan[3], 15);
        foreach (log_chan[k]) if (k < 4) exp_word[log_chan[k]] = {1'b1, sample_val(log_chan[k], salt)};
        check_all_data("R3 R4 data");
    endtask

    task automatic t_no_retrigger();
        salt = 12'h100; log_n = 0;
        bus_write(8'h04, 32'h0000_8423);
        wait_idle();
        check("R7 one start", log_n, 1);
        check("R7 chan", log_chan[0], 1);
        exp_word[1] = {1'b1, sample_val(1, salt)};
        check_all_data("R7 data");
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h15, 32'hFFFF_FFFF);
        bus_write(8'h58, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check("R8 read 0x00", v, 32'd0);
        bus_read(8'h08, v); check("R8 read 0x08", v, 32'd0);
        bus_read(8'h15, v); check("R8 read 0x15", v, 32'd0);
        bus_read(8'h58, v); check("R8 read 0x58", v, 32'd0);
        bus_read(8'h10, v); check("R8 status", v, 32'd0);
        bus_read(8'h04, v); check("R8 trig kept", v, 32'h8423);
        bus_read(8'h94, v); check("R8 power kept", v, 32'h4000);
        check_all_data("R8 data kept");
    endtask

    task automatic t_stray_done();
        @(negedge clk);
        stray = 1'b1;
        repeat (4) @(negedge clk);
        check_all_data("R9 data kept");
    endtask

    task automatic t_power_off_ready();
        logic [31:0] v;
        bus_write(8'h94, 32'h0);
        bus_write(8'h04, 32'h0);
        log_n = 0;
        bus_write(8'h04, 32'h0000_0001);
        repeat (20) @(negedge clk);
        check("R6 dropped", log_n, 0);
        bus_read(8'h10, v); check("R6 status", v, 32'd0);
        check_all_data("R6 ready kept");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_word[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_power_off();
        t_single();
        t_multi();
        t_no_retrigger();
        t_reserved();
        t_stray_done();
        t_power_off_ready();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule